// File: doc/BRIEF.md
# Pipelined Signed Multi-Operand Adder Tree

This block combines N two's-complement operands into one signed result. Each operand port has a fixed sign chosen at elaboration, either add or subtract, so that a configuration such as add/subtract/add produces a − b + c. The terms are reduced through a balanced binary tree of two-input adders. The result is wide enough that no legal operand set can overflow it.

With pipelining selected, a register follows every tree level. A single load strobe advances all levels together. The strobe is gated by a cyclic phase mask and by an optional clock-enable, so the tree samples only on the selected phases of a repeating cycle. An optional asynchronous clear empties the pipeline and restarts the phase count. With pipelining off, the tree is purely combinational.

Top module: `addtree_top`

## Requirements
- R1: `o_sum` is the signed sum of all operands. Port i occupies bits [i*OP_W +: OP_W] of `i_ops` and is subtracted when bit i of SUB_MASK is 1, otherwise it is added.
- R2: SUB_MASK bits at positions N_OPS and above are ignored, so any port without a set bit adds. The configuration is rejected at elaboration when N_OPS < 2 or when two neighbouring ports both subtract.
- R3: `o_sum` is OP_W + ceil(log2(N_OPS)) bits wide and holds the exact sum at the most negative and most positive operand extremes of a legal configuration.
- R4: With PIPE_EN = 0, `o_sum` follows `i_ops` in the same cycle, and `ena`, `aclr` and the phase mask have no effect on it.
- R5: With PIPE_EN = 1, the sum of the operands captured at a load appears on `o_sum` after ceil(log2(N_OPS)) loads. With an all-ones mask and loads every cycle, this is that many clock cycles.
- R6: A phase counter runs 0..PHASE_LEN-1 and starts at 0 after a clear. A load happens in phase p only when PHASE_MASK bit [PHASE_LEN-1-p] is 1, so the mask reads left to right as phase order. Operands presented in other phases are never captured.
- R7: With USE_ENA = 1, a low `ena` freezes the pipeline registers and the phase counter. With USE_ENA = 0, `ena` is ignored.
- R8: With USE_CLR = 1, a high `aclr` immediately zeroes every pipeline register and the phase counter. With USE_CLR = 0, `aclr` is ignored.
- R9: While `rst_n` is low, every pipeline register and the phase counter are zero, so a pipelined `o_sum` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| aclr | input | 1 | Asynchronous clear of pipeline and phase counter, active high, used when USE_CLR = 1 |
| ena | input | 1 | Clock enable for pipeline and phase counter, used when USE_ENA = 1 |
| i_ops | input | N_OPS*OP_W | Packed signed operands, port 0 in the lowest bits |
| o_sum | output | OP_W+ceil(log2(N_OPS)) | Signed result |

## Verification
A wrong per-port sign or a mis-wired tree node shows on the combinational result in the same cycle that the operands change. An exhaustive sweep of a three-port variant, together with extreme and pseudo-random operand sets on a five-port variant, exposes this. A phase counter that is off by one, or that advances while the enable is low, makes the pipelined result carry the sum of a neighbouring sample within one mask period. A level register that loads at the wrong time shows a stale or skipped sum after the pipeline depth in loads. A clear that misses a register, or that touches an instance where it is disabled, shows on the very next sample.

// File: rtl/addtree_pkg.sv
`timescale 1ns/1ps
package addtree_pkg;

  // smallest r with 2**r >= n
  function automatic int ceil_log2(input int n);
    for (int r = 0; r < 32; r++) begin
      if ((1 << r) >= n) return r;
    end
    return 32;
  endfunction

  // number of nodes remaining after k reduction levels
  function automatic int level_count(input int n, input int k);
    return (n + (1 << k) - 1) >> k;
  endfunction

  // neighbouring subtract ports are not permitted
  function automatic bit subs_legal(input logic [63:0] m, input int n);
    for (int i = 1; i < n; i++) begin
      if (m[i] && m[i-1]) return 1'b0;
    end
    return 1'b1;
  endfunction

endpackage

// File: rtl/addtree_sign.sv
`timescale 1ns/1ps
module addtree_sign #(
  parameter int          N_OPS    = 5,
  parameter int          OP_W     = 8,
  parameter int          RES_W    = 11,
  parameter logic [63:0] SUB_MASK = 64'h0
) (
  input  logic [N_OPS*OP_W-1:0]  i_ops,
  output logic [N_OPS*RES_W-1:0] o_terms
);

  // widen each operand to result precision before applying its sign,
  // so negating the most negative input cannot wrap
  for (genvar gi = 0; gi < N_OPS; gi++) begin : g_port
    logic signed [RES_W-1:0] widened;
    assign widened = RES_W'($signed(i_ops[gi*OP_W +: OP_W]));
    if (SUB_MASK[gi]) begin : g_sub
      assign o_terms[gi*RES_W +: RES_W] = -widened;
    end else begin : g_add
      assign o_terms[gi*RES_W +: RES_W] = widened;
    end
  end

endmodule

// File: rtl/addtree_phase.sv
`timescale 1ns/1ps
module addtree_phase
  import addtree_pkg::*;
#(
  parameter int          PHASE_LEN  = 1,
  parameter logic [31:0] PHASE_MASK = 32'h1
) (
  input  logic clk,
  input  logic clr_n,
  input  logic adv,
  output logic o_load,
  output logic [((PHASE_LEN > 1) ? ceil_log2(PHASE_LEN) : 1)-1:0] o_phase
);

  localparam int PH_W = (PHASE_LEN > 1) ? ceil_log2(PHASE_LEN) : 1;
  localparam logic [PH_W-1:0] LAST = PH_W'(PHASE_LEN - 1);

  // mask reorganised so that entry p is the flag of phase p
  logic [PHASE_LEN-1:0] sel_by_phase;
  for (genvar gp = 0; gp < PHASE_LEN; gp++) begin : g_sel
    assign sel_by_phase[gp] = PHASE_MASK[PHASE_LEN-1-gp];
  end

  logic [PH_W-1:0] phase_q;
  logic            phase_hit;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      phase_q <= '0;
    end else if (adv) begin
      phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end
  end

  assign phase_hit = sel_by_phase[phase_q];
  assign o_load    = adv & phase_hit;
  assign o_phase   = phase_q;

  a_r6_phase_range: assert property (@(posedge clk) disable iff (!clr_n)
    o_phase <= LAST);

  a_r6_phase_wrap: assert property (@(posedge clk) disable iff (!clr_n)
    (adv && o_phase == LAST) |=> o_phase == '0);

  a_r7_phase_hold: assert property (@(posedge clk) disable iff (!clr_n)
    !adv |=> $stable(o_phase));

  a_r6_load_needs_adv: assert property (@(posedge clk) disable iff (!clr_n)
    o_load |-> adv);

endmodule

// File: rtl/addtree_level.sv
`timescale 1ns/1ps
module addtree_level #(
  parameter int RES_W  = 11,
  parameter int IN_CNT = 5,
  parameter bit PIPE   = 1'b1
) (
  input  logic                              clk,
  input  logic                              clr_n,
  input  logic                              load,
  input  logic [IN_CNT*RES_W-1:0]           d,
  output logic [((IN_CNT+1)/2)*RES_W-1:0]   q
);

  localparam int OUT_CNT = (IN_CNT + 1) / 2;

  logic [OUT_CNT*RES_W-1:0] pair_sum;

  // pair neighbouring nodes; an odd last node passes through
  for (genvar gj = 0; gj < OUT_CNT; gj++) begin : g_node
    if (2*gj + 1 < IN_CNT) begin : g_add
      assign pair_sum[gj*RES_W +: RES_W] =
        d[(2*gj)*RES_W +: RES_W] + d[(2*gj+1)*RES_W +: RES_W];
    end else begin : g_pass
      assign pair_sum[gj*RES_W +: RES_W] = d[(2*gj)*RES_W +: RES_W];
    end
  end

  if (PIPE) begin : g_reg
    always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) begin
        q <= '0;
      end else if (load) begin
        q <= pair_sum;
      end
    end

    a_r5_level_capture: assert property (@(posedge clk) disable iff (!clr_n)
      load |=> q == $past(pair_sum));

    a_r7_level_hold: assert property (@(posedge clk) disable iff (!clr_n)
      !load |=> $stable(q));
  end else begin : g_comb
    assign q = pair_sum;
  end

endmodule

// File: rtl/addtree_top.sv
`timescale 1ns/1ps
module addtree_top
  import addtree_pkg::*;
#(
  parameter int          N_OPS      = 5,
  parameter int          OP_W       = 8,
  parameter logic [63:0] SUB_MASK   = 64'h0A,
  parameter bit          PIPE_EN    = 1'b1,
  parameter int          PHASE_LEN  = 1,
  parameter logic [31:0] PHASE_MASK = 32'h1,
  parameter bit          USE_ENA    = 1'b1,
  parameter bit          USE_CLR    = 1'b1
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                aclr,
  input  logic                                ena,
  input  logic [N_OPS*OP_W-1:0]               i_ops,
  output logic [OP_W+ceil_log2(N_OPS)-1:0]    o_sum
);

  localparam int DEPTH = ceil_log2(N_OPS);
  localparam int RES_W = OP_W + DEPTH;
  localparam int PH_W  = (PHASE_LEN > 1) ? ceil_log2(PHASE_LEN) : 1;

  // configuration checks at elaboration
  if (N_OPS < 2) begin : g_bad_count
    $error("addtree_top: at least two operands are required");
  end
  if (!subs_legal(SUB_MASK, N_OPS)) begin : g_bad_signs
    $error("addtree_top: neighbouring ports may not both subtract");
  end
  if (PHASE_LEN < 1 || PHASE_LEN > 32) begin : g_bad_phase
    $error("addtree_top: phase mask length must be 1 to 32");
  end

  // control: merged clear and advance strobe
  logic clr_n;
  logic adv;
  logic load;
  logic [PH_W-1:0] phase;

  assign clr_n = rst_n & ~(USE_CLR & aclr);
  assign adv   = USE_ENA ? ena : 1'b1;

  addtree_phase #(
    .PHASE_LEN  (PHASE_LEN),
    .PHASE_MASK (PHASE_MASK)
  ) u_phase (
    .clk     (clk),
    .clr_n   (clr_n),
    .adv     (adv),
    .o_load  (load),
    .o_phase (phase)
  );

  // tree datapath
  logic [N_OPS*RES_W-1:0] stage [DEPTH+1];

  addtree_sign #(
    .N_OPS    (N_OPS),
    .OP_W     (OP_W),
    .RES_W    (RES_W),
    .SUB_MASK (SUB_MASK)
  ) u_sign (
    .i_ops   (i_ops),
    .o_terms (stage[0])
  );

  for (genvar gk = 1; gk <= DEPTH; gk++) begin : g_level
    localparam int IN_CNT  = level_count(N_OPS, gk - 1);
    localparam int OUT_CNT = level_count(N_OPS, gk);

    addtree_level #(
      .RES_W  (RES_W),
      .IN_CNT (IN_CNT),
      .PIPE   (PIPE_EN)
    ) u_lvl (
      .clk   (clk),
      .clr_n (clr_n),
      .load  (load),
      .d     (stage[gk-1][IN_CNT*RES_W-1:0]),
      .q     (stage[gk][OUT_CNT*RES_W-1:0])
    );

    assign stage[gk][N_OPS*RES_W-1:OUT_CNT*RES_W] = '0;
  end

  assign o_sum = stage[DEPTH][RES_W-1:0];

  // straight-line reference sum, one bit wider than the result
  function automatic logic signed [RES_W:0] linear_sum(input logic [N_OPS*OP_W-1:0] v);
    logic signed [RES_W:0] acc;
    acc = '0;
    for (int i = 0; i < N_OPS; i++) begin
      if (SUB_MASK[i]) acc = acc - (RES_W+1)'($signed(v[i*OP_W +: OP_W]));
      else             acc = acc + (RES_W+1)'($signed(v[i*OP_W +: OP_W]));
    end
    return acc;
  endfunction

  logic signed [RES_W:0] ref_wide;
  assign ref_wide = linear_sum(i_ops);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    ref_wide[RES_W] == ref_wide[RES_W-1]);

  if (!PIPE_EN) begin : g_comb_chk
    a_r1_tree_sum: assert property (@(posedge clk) disable iff (!rst_n)
      $signed(o_sum) == ref_wide);
  end else begin : g_pipe_chk
    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (USE_CLR && aclr) |-> (o_sum == '0 && phase == '0));
  end

endmodule

// File: tb/test_addtree_top.sv
`timescale 1ns/1ps
module test_addtree_top;

  localparam int W   = 4;
  localparam int N   = 5;
  localparam int RW  = 7;
  localparam int N3  = 3;
  localparam int RW3 = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n, aclr, ena;
  logic [N*W-1:0]   ops;
  logic [N3*W-1:0]  ops3;
  logic [RW-1:0]    out_comb, out_b, out_c;
  logic [RW3-1:0]   out3;

  // five ports, +,-,+,-,+ ; combinational
  addtree_top #(.N_OPS(N), .OP_W(W), .SUB_MASK(64'h0A), .PIPE_EN(1'b0))
  i_addtree_top_comb (.clk(clk), .rst_n(rst_n), .aclr(aclr), .ena(ena),
                      .i_ops(ops), .o_sum(out_comb));

  // pipelined, load every cycle, enable ignored, clear used
  addtree_top #(.N_OPS(N), .OP_W(W), .SUB_MASK(64'h0A), .PIPE_EN(1'b1),
                .PHASE_LEN(1), .PHASE_MASK(32'h1), .USE_ENA(1'b0), .USE_CLR(1'b1))
  i_addtree_top (.clk(clk), .rst_n(rst_n), .aclr(aclr), .ena(ena),
                 .i_ops(ops), .o_sum(out_b));

  // pipelined, mask "0100", enable used, clear ignored
  addtree_top #(.N_OPS(N), .OP_W(W), .SUB_MASK(64'h0A), .PIPE_EN(1'b1),
                .PHASE_LEN(4), .PHASE_MASK(32'b0100), .USE_ENA(1'b1), .USE_CLR(1'b0))
  i_addtree_top_phased (.clk(clk), .rst_n(rst_n), .aclr(aclr), .ena(ena),
                        .i_ops(ops), .o_sum(out_c));

  // three ports a-b+c; mask bits above port 2 are set and must be ignored
  addtree_top #(.N_OPS(N3), .OP_W(W), .SUB_MASK(64'hF2), .PIPE_EN(1'b0))
  i_addtree_top_three (.clk(clk), .rst_n(rst_n), .aclr(aclr), .ena(ena),
                       .i_ops(ops3), .o_sum(out3));

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // bench arithmetic: signs +,-,+,-,+
  function automatic int exp5(input logic [N*W-1:0] v);
    int s = 0;
    for (int i = 0; i < N; i++) begin
      int x = int'($signed(v[i*W +: W]));
      if (i % 2 == 1) s -= x; else s += x;
    end
    return s;
  endfunction

  function automatic logic [N*W-1:0] corner(input int k);
    logic [W-1:0] lo, hi;
    lo = 4'h8; hi = 4'h7;
    case (k % 4)
      0:       return {lo, hi, lo, hi, lo};  // most negative sum
      1:       return {hi, lo, hi, lo, hi};  // most positive sum
      2:       return {N{lo}};
      default: return {N{hi}};
    endcase
  endfunction

  int  pb[3];
  int  pc[3];
  int  phc;
  bit  sel_c[4] = '{1'b0, 1'b1, 1'b0, 1'b0};
  logic [31:0] rng = 32'h1ACE5EED;
  bit  finished = 1'b0;

  initial begin
    #1000000;
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; aclr = 1'b0; ena = 1'b0; ops = '0; ops3 = '0;
    pb = '{0, 0, 0}; pc = '{0, 0, 0}; phc = 0;
    repeat (3) @(negedge clk);
    chk("R9", int'($signed(out_b)), 0);
    chk("R9", int'($signed(out_c)), 0);
    rst_n = 1'b1;

    // R2 / R1: exhaustive sweep of the three-port variant
    for (int a = -8; a < 8; a++) begin
      for (int b = -8; b < 8; b++) begin
        for (int c = -8; c < 8; c++) begin
          ops3 = {4'(c), 4'(b), 4'(a)};
          #1;
          chk("R2", int'($signed(out3)), a - b + c);
        end
      end
    end

    @(negedge clk);
    for (int m = 0; m < 3000; m++) begin
      int s;
      @(negedge clk);
      chk((m < 20) ? "R3" : (ena ? "R1" : "R4"), int'($signed(out_comb)), exp5(ops));
      chk(ena ? "R5" : "R7", int'($signed(out_b)), pb[2]);
      chk(ena ? "R6" : "R7", int'($signed(out_c)), pc[2]);
      if (m == 1500) begin
        aclr = 1'b1;
        #1;
        chk("R8", int'($signed(out_b)), 0);
        chk("R8", int'($signed(out_c)), pc[2]);
        chk("R4", int'($signed(out_comb)), exp5(ops));
        pb = '{0, 0, 0};
      end else if (m == 1501) begin
        aclr = 1'b0;
      end

      if (m < 16) begin
        ops = corner(m);
      end else begin
        rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
        ops = rng[N*W-1:0];
      end
      ena = (m < 300) ? 1'b1 : (rng[27:26] != 2'b00);

      s = exp5(ops);
      if (m != 1500) begin
        pb[2] = pb[1]; pb[1] = pb[0]; pb[0] = s;
      end
      if (ena) begin
        if (sel_c[phc]) begin
          pc[2] = pc[1]; pc[1] = pc[0]; pc[0] = s;
        end
        phc = (phc + 1) % 4;
      end
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule